// File: doc/BRIEF.md
# PWM Edge Action Qualifier with Shadowed Force Override

This block turns the events of a shared time-base counter into two PWM output levels, channel A and channel B. An external counter supplies its value, its count direction, a zero strobe and a period strobe. A one-cycle time-base tick marks each counter step. Two compare values are also supplied. On every tick the block finds the events present: zero, period, compare A matched while counting up, and compare B matched while counting up. Each channel's action word then sets, clears, toggles or keeps that channel's output.

A continuous force override can pin either output low or high, whatever the events do. Software writes the override into a shadow copy. The shadow moves into the active override at a reload point chosen by a 2-bit mode: on zero, on period, on either, or immediately on the next tick. The block is configured through a simple word-write port.

Top module: `pwm_action_qual`

## Requirements
- R1: After reset both outputs are low, and the action words, force shadow, active force and reload mode are all 0, so a later tick with zero or period present leaves both outputs low.
- R2: Each 2-bit action code means: 00 keep the level, 01 drive low, 10 drive high, 11 invert the current level.
- R3: Each channel's action word holds the zero action in bits 1:0, the period action in bits 3:2, the compare-A-up action in bits 5:4 and the compare-B-up action in bits 9:8. A compare event exists only when the counter equals that compare value and the direction input shows up-counting.
- R4: An output changes only on a clock edge where the tick input is high. Event strobes without a tick have no effect.
- R5: When several events fall on one tick, only the highest-priority event whose action code is nonzero applies. The order from highest is period, then compare A, then compare B, then zero.
- R6: An active force code of 01 holds the output low and 10 holds it high, overriding every event action. Codes 00 and 11 release the output to its event actions.
- R7: The force shadow moves into the active force on a tick that carries the selected reload point. Reload mode 00 means zero, 01 means period, 10 means zero or period and 11 means any tick. Until then the previous active force stays in control.
- R8: In immediate mode (11) a new shadow value controls the output from the first tick after the write.
- R9: Register map on the write port: address 0 is the channel A action word, address 1 is the channel B action word, address 2 holds the reload mode in bits 7:6, and address 3 holds the force shadow with channel A in bits 1:0 and channel B in bits 3:2.
- R10: With normal polarity (high on zero and period, low on compare-up) the output rises at zero. With the inverted word (low on zero and period, high on compare-up) it falls at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tbTick | input | 1 | Time-base step enable, one cycle per counter step |
| ctrVal | input | 16 | Time-base counter value |
| ctrDirUp | input | 1 | High while the counter counts up |
| zeroStb | input | 1 | Counter is at zero |
| periodStb | input | 1 | Counter is at period |
| cmpAVal | input | 16 | Compare value A |
| cmpBVal | input | 16 | Compare value B |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register write address |
| regWrData | input | 16 | Register write data |
| pwmA | output | 1 | Channel A output |
| pwmB | output | 1 | Channel B output |

## Verification
Two functions can fall on one tick: a force reload and an event action that is due on that same tick. A third case is several events at once, such as zero, period and a compare-up match together. The bench provokes this by raising zero, period and a matching counter value in one tick. It also reloads the force shadow on the same zero or period tick whose action word would move the output the opposite way. The result is judged by whether the output follows the newly loaded force, or the highest-priority nonzero action, in the cycle right after that tick edge.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;
  localparam int NUM_EVT = 4;

  typedef struct packed {
    logic tick;
    logic zero;
    logic period;
    logic cmpA;
    logic cmpB;
    logic loadForce;
  } evtStrobes_t;

  typedef enum logic [1:0] {
    ACT_KEEP   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } actCode_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_IMMED  = 2'b11
  } reloadMode_e;

  // Event slots in priority order: index 0 is the highest.
  function automatic int evtLsb(input int idx);
    case (idx)
      0:       return 2;  // period
      1:       return 4;  // compare A up
      2:       return 8;  // compare B up
      default: return 0;  // zero
    endcase
  endfunction
endpackage

// File: rtl/pwmaq_ctrl.sv
module pwmaq_ctrl
  import pwmaq_pkg::*;
#(
  parameter int CTR_W  = 16,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2,
  parameter int NUM_CH = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tbTick,
  input  logic [CTR_W-1:0]              ctrVal,
  input  logic                          ctrDirUp,
  input  logic                          zeroStb,
  input  logic                          periodStb,
  input  logic [CTR_W-1:0]              cmpAVal,
  input  logic [CTR_W-1:0]              cmpBVal,
  input  logic                          regWrEn,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic [REG_W-1:0]              regWrData,
  output evtStrobes_t                   strobes,
  output logic [NUM_CH-1:0][REG_W-1:0]  actCtl,
  output logic [2*NUM_CH-1:0]           forceShadow
);
  localparam logic [ADDR_W-1:0] ADDR_MODE   = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] ADDR_SHADOW = ADDR_W'(NUM_CH + 1);
  localparam int MODE_LSB = 6;

  reloadMode_e reloadMode;
  logic        loadPoint;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actCtl      <= '0;
      forceShadow <= '0;
      reloadMode  <= RLD_ZERO;
    end else if (regWrEn) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        if (regAddr == ADDR_W'(ch)) actCtl[ch] <= regWrData;
      if (regAddr == ADDR_MODE)
        reloadMode <= reloadMode_e'(regWrData[MODE_LSB +: 2]);
      if (regAddr == ADDR_SHADOW)
        forceShadow <= regWrData[2*NUM_CH-1:0];
    end
  end

  always_comb begin
    case (reloadMode)
      RLD_ZERO:   loadPoint = zeroStb;
      RLD_PERIOD: loadPoint = periodStb;
      RLD_EITHER: loadPoint = zeroStb | periodStb;
      default:    loadPoint = 1'b1;
    endcase
  end

  always_comb begin
    strobes.tick      = tbTick;
    strobes.zero      = tbTick & zeroStb;
    strobes.period    = tbTick & periodStb;
    strobes.cmpA      = tbTick & ctrDirUp & (ctrVal == cmpAVal);
    strobes.cmpB      = tbTick & ctrDirUp & (ctrVal == cmpBVal);
    strobes.loadForce = tbTick & loadPoint;
  end

  // R1
  cfg_reset_chk: assert property (@(posedge clk)
    !rstN |=> (actCtl == '0 && forceShadow == '0));

  // R7
  zero_mode_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reloadMode == RLD_ZERO && strobes.loadForce) |-> zeroStb);

  // R3
  cmp_up_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.cmpA || strobes.cmpB) |-> (ctrDirUp && tbTick));
endmodule

// File: rtl/pwmaq_chan.sv
module pwmaq_chan
  import pwmaq_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  evtStrobes_t      strobes,
  input  logic [REG_W-1:0] actCtl,
  input  logic [1:0]       shadowForce,
  output logic             pwmOut
);
  logic [1:0]         activeForce;
  logic [1:0]         effForce;
  logic [1:0]         actSel;
  logic [NUM_EVT-1:0] evtHit;
  logic               nxtLevel;

  assign evtHit = {strobes.zero, strobes.cmpB, strobes.cmpA, strobes.period};
  assign effForce = strobes.loadForce ? shadowForce : activeForce;

  // Walk from lowest to highest priority so the highest nonzero action wins.
  always_comb begin
    actSel = ACT_KEEP;
    for (int i = NUM_EVT - 1; i >= 0; i--)
      if (evtHit[i] && actCtl[evtLsb(i) +: 2] != ACT_KEEP)
        actSel = actCtl[evtLsb(i) +: 2];
  end

  always_comb begin
    case (effForce)
      2'b01:   nxtLevel = 1'b0;
      2'b10:   nxtLevel = 1'b1;
      default: begin
        case (actCode_e'(actSel))
          ACT_LOW:    nxtLevel = 1'b0;
          ACT_HIGH:   nxtLevel = 1'b1;
          ACT_TOGGLE: nxtLevel = ~pwmOut;
          default:    nxtLevel = pwmOut;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeForce <= 2'b00;
      pwmOut      <= 1'b0;
    end else begin
      if (strobes.loadForce) activeForce <= shadowForce;
      if (strobes.tick)      pwmOut      <= nxtLevel;
    end
  end

  // R1
  out_reset_chk: assert property (@(posedge clk) !rstN |=> !pwmOut);

  // R4
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick |=> $stable(pwmOut));

  // R6
  force_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.loadForce && activeForce == 2'b01) |=> !pwmOut);

  // R6
  force_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.tick && !strobes.loadForce && activeForce == 2'b10) |=> pwmOut);

  // R8
  load_takes_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadForce && shadowForce == 2'b10) |=> (pwmOut && activeForce == 2'b10));
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwmaq_pkg::*;
#(
  parameter int CTR_W  = 16,
  parameter int REG_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tbTick,
  input  logic [CTR_W-1:0]  ctrVal,
  input  logic              ctrDirUp,
  input  logic              zeroStb,
  input  logic              periodStb,
  input  logic [CTR_W-1:0]  cmpAVal,
  input  logic [CTR_W-1:0]  cmpBVal,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  output logic              pwmA,
  output logic              pwmB
);
  localparam int NUM_CH = 2;

  evtStrobes_t                  strobes;
  logic [NUM_CH-1:0][REG_W-1:0] actCtl;
  logic [2*NUM_CH-1:0]          forceShadow;
  logic [NUM_CH-1:0]            pwmVec;

  pwmaq_ctrl #(
    .CTR_W(CTR_W), .REG_W(REG_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tbTick(tbTick), .ctrVal(ctrVal),
    .ctrDirUp(ctrDirUp), .zeroStb(zeroStb), .periodStb(periodStb),
    .cmpAVal(cmpAVal), .cmpBVal(cmpBVal), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .strobes(strobes),
    .actCtl(actCtl), .forceShadow(forceShadow)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pwmaq_chan #(.REG_W(REG_W)) u_chan (
      .clk(clk), .rstN(rstN), .strobes(strobes),
      .actCtl(actCtl[ch]), .shadowForce(forceShadow[2*ch +: 2]),
      .pwmOut(pwmVec[ch])
    );
  end

  assign pwmA = pwmVec[0];
  assign pwmB = pwmVec[1];
endmodule

// File: tb/sim_pwm_action_qual.sv
module sim_pwm_action_qual;
  localparam real CLK_NS = 4.0;
  localparam int  NVEC   = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tbTick = 1'b0;
  logic [15:0] ctrVal = '0;
  logic        ctrDirUp = 1'b1;
  logic        zeroStb = 1'b0;
  logic        periodStb = 1'b0;
  logic [15:0] cmpAVal = 16'd10;
  logic [15:0] cmpBVal = 16'd20;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        pwmA, pwmB;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_NS/2) clk = ~clk;

  pwm_action_qual u0 (
    .clk(clk), .rstN(rstN), .tbTick(tbTick), .ctrVal(ctrVal),
    .ctrDirUp(ctrDirUp), .zeroStb(zeroStb), .periodStb(periodStb),
    .cmpAVal(cmpAVal), .cmpBVal(cmpBVal), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .pwmA(pwmA), .pwmB(pwmB)
  );

  // {actA, actB, zero, period, ctr, up, expA, expB}, applied in order.
  localparam logic [52:0] VEC [NVEC] = '{
    {16'h0002, 16'h0001, 1'b1, 1'b0, 16'd0,  1'b1, 1'b1, 1'b0}, // R3 zero event
    {16'h0010, 16'h0020, 1'b0, 1'b0, 16'd10, 1'b1, 1'b0, 1'b1}, // R2 cmpA up
    {16'h0010, 16'h0020, 1'b0, 1'b0, 16'd10, 1'b0, 1'b0, 1'b1}, // R3 down: no match
    {16'h0300, 16'h0300, 1'b0, 1'b0, 16'd20, 1'b1, 1'b1, 1'b0}, // R2 cmpB toggle
    {16'h0006, 16'h0002, 1'b1, 1'b1, 16'd0,  1'b1, 1'b0, 1'b1}, // R5 period over zero
    {16'h0021, 16'h0031, 1'b1, 1'b0, 16'd10, 1'b1, 1'b1, 1'b0}, // R5 cmp over zero
    {16'h0024, 16'h0018, 1'b0, 1'b1, 16'd10, 1'b1, 1'b0, 1'b1}, // R5 period over cmp
    {16'h0000, 16'h0000, 1'b1, 1'b0, 16'd0,  1'b1, 1'b0, 1'b1}, // R2 keep
    {16'h001A, 16'h0025, 1'b1, 1'b0, 16'd0,  1'b1, 1'b1, 1'b0}  // R10 polarity
  };

  task automatic check(input logic act, input logic exp, input string req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] addr, input logic [15:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = addr; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic tickOnce(input logic z, input logic p, input logic [15:0] c, input logic up);
    @(negedge clk);
    tbTick = 1'b1; zeroStb = z; periodStb = p; ctrVal = c; ctrDirUp = up;
    @(negedge clk);
    tbTick = 1'b0; zeroStb = 1'b0; periodStb = 1'b0;
  endtask

  task automatic checkPair(input logic ea, input logic eb, input string req, input string what);
    check(pwmA, ea, req, {what, " A"});
    check(pwmB, eb, req, {what, " B"});
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkPair(1'b0, 1'b0, "R1", "reset level");
    tickOnce(1'b1, 1'b1, 16'd10, 1'b1);
    checkPair(1'b0, 1'b0, "R1", "cleared action words");

    for (int i = 0; i < NVEC; i++) begin
      writeReg(2'd0, VEC[i][52:37]);
      writeReg(2'd1, VEC[i][36:21]);
      tickOnce(VEC[i][20], VEC[i][19], VEC[i][18:3], VEC[i][2]);
      checkPair(VEC[i][1], VEC[i][0], "R2/R3/R5/R10", $sformatf("vector %0d", i));
    end

    // R4: strobes without a tick, toggle-on-zero word armed
    writeReg(2'd0, 16'h0003);
    @(negedge clk);
    zeroStb = 1'b1; periodStb = 1'b1; ctrVal = 16'd10;
    repeat (3) @(negedge clk);
    zeroStb = 1'b0; periodStb = 1'b0;
    checkPair(1'b1, 1'b0, "R4", "no tick hold");

    writeReg(2'd0, 16'h001A);
    writeReg(2'd1, 16'h0025);
    // R9/R8: immediate mode, shadow A=low B=high, tick without events
    writeReg(2'd2, 16'h00C0);
    writeReg(2'd3, 16'h0009);
    tickOnce(1'b0, 1'b0, 16'd5, 1'b1);
    checkPair(1'b0, 1'b1, "R8", "immediate force");
    // R6: force overrides zero action
    tickOnce(1'b1, 1'b0, 16'd0, 1'b1);
    checkPair(1'b0, 1'b1, "R6", "force over zero action");
    // R7: zero reload mode, release waits for zero
    writeReg(2'd2, 16'h0000);
    writeReg(2'd3, 16'h0000);
    tickOnce(1'b0, 1'b1, 16'd40, 1'b1);
    checkPair(1'b0, 1'b1, "R7", "no reload on period");
    tickOnce(1'b1, 1'b0, 16'd0, 1'b1);
    checkPair(1'b1, 1'b0, "R7", "release on zero");
    // R6: code 11 releases; either-mode reload on zero
    writeReg(2'd1, 16'h0003);
    writeReg(2'd2, 16'h0080);
    writeReg(2'd3, 16'h000D);
    tickOnce(1'b1, 1'b0, 16'd0, 1'b1);
    checkPair(1'b0, 1'b1, "R6", "code 11 releases, 01 forces");
    // R7: period mode ignores zero
    writeReg(2'd2, 16'h0040);
    writeReg(2'd3, 16'h0000);
    tickOnce(1'b1, 1'b0, 16'd0, 1'b1);
    checkPair(1'b0, 1'b0, "R7", "no reload on zero");
    tickOnce(1'b0, 1'b1, 16'd40, 1'b1);
    checkPair(1'b1, 1'b0, "R7", "reload on period");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule